// File: doc/BRIEF.md
# Toggle-Chain Gray Code Counter

A free-running counter that steps through the reflected Gray sequence by deciding per bit whether to flip, rather than incrementing a binary value and converting it. A hidden phase register, flipped on every count, tracks the parity of the current code. While it is clear, bit 0 flips. While it is set, a rippling "everything below is zero" chain picks out the bit just above the lowest set bit. The most significant bit also flips when it is itself the lowest set bit, and that flip returns the counter to zero.

The width is a parameter, 24 bits by default. The counter advances on each clock edge where the enable input is high. A synchronous reset clears the counter. A one-cycle wrap flag marks the return to all zeros.

Top module: `gray_toggle_counter`

## Requirements
- R1: After k enabled counts following reset, the output equals (k mod 2^WIDTH) XOR ((k mod 2^WIDTH) >> 1). For 4 bits the codes run 0000, 0001, 0011, 0010, 0110 ... 1000, then 0000 again.
- R2: Every enabled count changes exactly one output bit. This includes the count from the code with only the MSB set back to all zeros.
- R3: When the current code has an even number of ones, an enabled count flips bit 0.
- R4: When the current code has an odd number of ones, an enabled count flips the bit one position above the lowest set bit. If the lowest set bit is the MSB, it flips the MSB instead.
- R5: While the enable input is low, the output does not change and the count sequence does not advance.
- R6: The wrap output is high for exactly the one cycle in which the output has just returned to zero through an enabled count. It is low in every other cycle.
- R7: A synchronous active-high reset sets the output to zero and the wrap flag to low. The next enabled count after reset gives code 1.
- R8: The width defaults to 24, and the counter runs freely through all 2^WIDTH codes with no terminal stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Advance by one code on this edge when high |
| grayOut | output | WIDTH | Current Gray code |
| wrapPulse | output | 1 | High for one cycle after the count that returns to zero |

## Verification
The enable and reset inputs are sampled on a rising edge, and their effect on both the code and the wrap flag appears after that same edge. No other register lies between an input and any result. The bench therefore drives its inputs on the falling edge. It advances its own integer count when the next rising edge occurs, and it compares both outputs at the falling edge that follows. A 4-bit instance runs through several complete periods next to the 24-bit default, so that the MSB and the wrap behaviour are exercised.

// File: rtl/gray_pkg.sv
package gray_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } grayStrobe_t;
endpackage

// File: rtl/gray_ctrl.sv
module gray_ctrl
  import gray_pkg::*;
(
  input  logic        rst,
  input  logic        countEn,
  output grayStrobe_t strobe
);
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = countEn && !rst;
  end
endmodule

// File: rtl/gray_path.sv
module gray_path
  import gray_pkg::*;
#(
  parameter int WIDTH = 24
)(
  input  logic             clk,
  input  logic             rst,
  input  grayStrobe_t      strobe,
  output logic [WIDTH-1:0] grayQ,
  output logic             wrapQ
);
  localparam int MSB = WIDTH - 1;

  logic             phaseQ;
  logic [MSB-1:0]   zeroBelow;
  logic [MSB:0]     toggle;
  logic [MSB:0]     grayNext;

  // chain: zeroBelow[i] means bits i-1..0 are all zero
  assign zeroBelow[0] = 1'b1;
  generate
    for (genvar i = 1; i < MSB; i++) begin : g_zchain
      assign zeroBelow[i] = zeroBelow[i-1] & ~grayQ[i-1];
    end
  endgenerate

  assign toggle[0] = ~phaseQ;
  generate
    for (genvar n = 1; n < MSB; n++) begin : g_tog
      assign toggle[n] = phaseQ & grayQ[n-1] & zeroBelow[n-1];
    end
  endgenerate
  assign toggle[MSB] = phaseQ & (grayQ[MSB-1] | grayQ[MSB]) & zeroBelow[MSB-1];

  assign grayNext = grayQ ^ toggle;

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      grayQ  <= '0;
      phaseQ <= 1'b0;
      wrapQ  <= 1'b0;
    end else if (strobe.advance) begin
      grayQ  <= grayNext;
      phaseQ <= ~phaseQ;
      wrapQ  <= (grayNext == '0);
    end else begin
      wrapQ  <= 1'b0;
    end
  end

  p_one_bit_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> $countones(grayQ ^ $past(grayQ)) == 1);
  p_even_bit0_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && !phaseQ) |=> grayQ[0] != $past(grayQ[0]));
  p_phase_parity_r4: assert property (@(posedge clk) disable iff (rst)
    phaseQ == ^grayQ);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> $stable(grayQ) && $stable(phaseQ));
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    wrapQ |-> grayQ == '0);
  p_wrap_single_r6: assert property (@(posedge clk) disable iff (rst)
    wrapQ |=> !wrapQ);
  p_reset_r7: assert property (@(posedge clk)
    strobe.clear |=> (grayQ == '0) && !wrapQ && !phaseQ);
endmodule

// File: rtl/gray_toggle_counter.sv
module gray_toggle_counter
  import gray_pkg::*;
#(
  parameter int WIDTH = 24
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  output logic [WIDTH-1:0] grayOut,
  output logic             wrapPulse
);
  grayStrobe_t strobe;

  gray_ctrl u_ctrl (
    .rst     (rst),
    .countEn (countEn),
    .strobe  (strobe)
  );

  gray_path #(.WIDTH(WIDTH)) u_path (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .grayQ  (grayOut),
    .wrapQ  (wrapPulse)
  );
endmodule

// File: tb/gray_toggle_counter_test.sv
module gray_toggle_counter_test;
  localparam int WB = 24;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic countEn = 1'b0;
  logic [WB-1:0] grayBig;
  logic [WS-1:0] graySmall;
  logic wrapBig, wrapSmall;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int cntBig = 0, cntSmall = 0;
  bit expWrapBig = 0, expWrapSmall = 0;

  always #5 clk = ~clk;

  gray_toggle_counter uut (
    .clk(clk), .rst(rst), .countEn(countEn),
    .grayOut(grayBig), .wrapPulse(wrapBig)
  );

  gray_toggle_counter #(.WIDTH(WS)) uutSmall (
    .clk(clk), .rst(rst), .countEn(countEn),
    .grayOut(graySmall), .wrapPulse(wrapSmall)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int toGray(input int k);
    return k ^ (k >> 1);
  endfunction

  // expected flipped-bit index from the toggle rule
  function automatic int flipIndex(input int g, input int w);
    if (($countones(g) % 2) == 0) return 0;
    for (int b = 0; b < w; b++)
      if (g[b]) return (b == w - 1) ? b : b + 1;
    return 0;
  endfunction

  task automatic step(input bit r, input bit e);
    int prevSmall;
    int prevBig;
    prevSmall = graySmall;
    prevBig = grayBig;
    rst = r;
    countEn = e;
    @(posedge clk);
    if (r) begin
      cntBig = 0; cntSmall = 0; expWrapBig = 0; expWrapSmall = 0;
    end else if (e) begin
      cntBig = (cntBig + 1) % (1 << WB);
      cntSmall = (cntSmall + 1) % (1 << WS);
      expWrapBig = (cntBig == 0);
      expWrapSmall = (cntSmall == 0);
    end else begin
      expWrapBig = 0; expWrapSmall = 0;
    end
    @(negedge clk);
    if (r) begin
      check(grayBig == 0 && !wrapBig, "R7 reset big", grayBig, 0);
      check(graySmall == 0 && !wrapSmall, "R7 reset small", graySmall, 0);
    end else begin
      check(grayBig == WB'(toGray(cntBig)), "R1 R8 sequence big", grayBig, toGray(cntBig));
      check(graySmall == WS'(toGray(cntSmall)), "R1 sequence small", graySmall, toGray(cntSmall));
      check(wrapBig == expWrapBig, "R6 wrap big", wrapBig, expWrapBig);
      check(wrapSmall == expWrapSmall, "R6 wrap small", wrapSmall, expWrapSmall);
      if (e) begin
        check($countones(graySmall ^ WS'(prevSmall)) == 1, "R2 one bit small",
              graySmall ^ WS'(prevSmall), 1);
        check($countones(grayBig ^ WB'(prevBig)) == 1, "R2 one bit big",
              grayBig ^ WB'(prevBig), 1);
        if (($countones(prevSmall) % 2) == 0)
          check((graySmall ^ WS'(prevSmall)) == 1, "R3 even flips bit0",
                graySmall ^ WS'(prevSmall), 1);
        else
          check((graySmall ^ WS'(prevSmall)) == WS'(1 << flipIndex(prevSmall, WS)),
                "R4 odd flips above lowest set", graySmall ^ WS'(prevSmall),
                1 << flipIndex(prevSmall, WS));
      end else begin
        check(graySmall == WS'(prevSmall) && grayBig == WB'(prevBig), "R5 hold",
              graySmall, prevSmall);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    step(1, 0);
    step(1, 1);
    for (int i = 0; i < 40; i++) step(0, 1);
    for (int i = 0; i < 30; i++) step(0, (i % 3) != 0);
    step(1, 1);
    step(0, 1);
    check(graySmall == 1 && grayBig == 1, "R7 first code after reset", graySmall, 1);
    for (int i = 0; i < 60; i++) step(0, 1);
    for (int i = 0; i < 20; i++) step(0, (i % 2) == 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule